// File: doc/BRIEF.md
# Predicated FP32-to-BF16 Upper-Half Narrower

This block takes a vector of single-precision lanes and a prior destination vector. It converts each selected lane to bfloat16 and writes the result into the upper 16-bit half of the same 32-bit lane of the destination. The lower 16-bit half of every lane always keeps the prior destination bits. A predicate with one bit per byte selects the lanes. A mode input decides what happens to the upper half of an unselected lane: merge mode keeps the prior value, and zero mode clears it.

Each conversion is steered by a two-bit rounding mode and a flush-to-zero control. Two flags cover one operation: an inexact flag and an invalid flag. The datapath is combinational per lane, and the result, the old destination halves and the flags are captured in one output register stage. A result therefore appears on the outputs one clock after its inputs are presented. A lane classifier sorts each input into one of four kinds: NaN, infinity, flushed denormal, or finite. Every lane goes through this classifier, and there is no sequencing between operations.

Top module: `bfn_narrow_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, `dst_vec`, `inexact` and `invalid` become zero. Otherwise every output reflects the inputs sampled at the previous rising edge, so the latency is one cycle.
- R2: The result for source lane e (`src_vec[32e+31:32e]`) is written to `dst_vec[32e+31:32e+16]`.
- R3: Every lower half `dst_vec[32e+15:32e]` equals `old_dst[32e+15:32e]`, regardless of predicate, mode or source.
- R4: Lane e is active exactly when `pred[4e]` is 1. Predicate bits 4e+1 to 4e+3 have no effect.
- R5: When lane e is inactive and `zero_mode` is 0 (merge), the upper half equals `old_dst[32e+31:32e+16]`.
- R6: When lane e is inactive and `zero_mode` is 1, the upper half is 16'h0000.
- R7: With `round_mode` 2'b00 (nearest-even), the result is `src[31:16]` plus an increment. The increment is 1 when bit 15 is set and either bits 14:0 are nonzero or bit 16 is set. A carry rolls into the exponent, so the largest finite inputs can round up to infinity.
- R8: `round_mode` 2'b01 rounds toward +infinity: it adds 1 to `src[31:16]` when the sign is 0 and `src[15:0]` is nonzero. 2'b10 rounds toward -infinity: it adds 1 when the sign is 1 and `src[15:0]` is nonzero. 2'b11 truncates.
- R9: A NaN input (exponent all ones, fraction nonzero) gives {sign, 8'hFF, 1, src[21:16]}. Infinities and zeros convert exactly.
- R10: When `flush_den` is 1, an input with a zero exponent and a nonzero fraction gives {sign, 15'h0} and does not set `inexact`. When `flush_den` is 0, such an input is rounded by R7/R8.
- R11: `inexact` is 1 when any active finite, non-flushed lane has nonzero `src[15:0]`. Inactive lanes never set it.
- R12: `invalid` is 1 when any active lane holds a signaling NaN, meaning a NaN with fraction bit 22 clear. Inactive lanes never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_vec | input | VL | Source single-precision lanes |
| old_dst | input | VL | Prior destination vector |
| pred | input | VL/8 | Predicate, one bit per byte |
| zero_mode | input | 1 | 1 = clear inactive upper halves, 0 = keep them |
| round_mode | input | 2 | 00 nearest-even, 01 toward +inf, 10 toward -inf, 11 toward zero |
| flush_den | input | 1 | Flush denormal inputs to signed zero |
| dst_vec | output | VL | New destination vector |
| inexact | output | 1 | Some active lane discarded nonzero bits |
| invalid | output | 1 | Some active lane held a signaling NaN |

## Verification
The bench targets the exact-tie cases of nearest-even rounding. A design that always rounded half up would move 3F80_8000 to 3F81, and one that ignored the tie rule would leave 3F81_8000 at 3F81. It also drives the largest finite value under nearest-even and under truncation, where a missing carry or an unconditional increment gives the wrong exponent, and the directed modes on both signs, where a swapped mode encoding shows at once. Predicate bits other than 4e are set on inactive lanes, and NaNs are placed in inactive lanes. A design that decoded the wrong predicate bit, leaked flags from unselected lanes, or wrote into lower halves would change outputs that must stay fixed.

// File: rtl/bfn_pkg.sv
package bfn_pkg;

    typedef enum logic [1:0] {
        RM_NEAREST = 2'b00,
        RM_UP      = 2'b01,
        RM_DOWN    = 2'b10,
        RM_ZERO    = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        K_FINITE = 2'd0,
        K_NAN    = 2'd1,
        K_INF    = 2'd2,
        K_FLUSH  = 2'd3
    } kind_e;

    typedef struct packed {
        logic [15:0] val;
        logic        inexact;
        logic        snan;
    } cvt_res_t;

    localparam int LANE_W = 32;
    localparam int HALF_W = 16;

endpackage

// File: rtl/bfn_lane_cvt.sv
module bfn_lane_cvt
    import bfn_pkg::*;
(
    input  logic [LANE_W-1:0] fp_in,
    input  rmode_e            rm,
    input  logic              ftz,
    output cvt_res_t          res
);
    logic        sgn;
    logic [7:0]  expo;
    logic [22:0] frac;
    logic        lost;
    logic        inc;
    kind_e       kind;

    assign sgn  = fp_in[31];
    assign expo = fp_in[30:23];
    assign frac = fp_in[22:0];
    assign lost = |fp_in[15:0];

    always_comb begin
        if (expo == 8'hFF && frac != '0)
            kind = K_NAN;
        else if (expo == 8'hFF)
            kind = K_INF;
        else if (ftz && expo == 8'h00 && frac != '0)
            kind = K_FLUSH;
        else
            kind = K_FINITE;
    end

    always_comb begin
        unique case (rm)
            RM_NEAREST: inc = fp_in[15] & ((|fp_in[14:0]) | fp_in[16]);
            RM_UP:      inc = lost & ~sgn;
            RM_DOWN:    inc = lost & sgn;
            RM_ZERO:    inc = 1'b0;
            default:    inc = 1'b0;
        endcase
    end

    always_comb begin
        res = '0;
        unique case (kind)
            K_NAN: begin
                res.val  = {sgn, 8'hFF, 1'b1, frac[21:16]};
                res.snan = ~frac[22];
            end
            K_INF:   res.val = {sgn, 8'hFF, 7'h00};
            K_FLUSH: res.val = {sgn, 15'h0000};
            K_FINITE: begin
                res.val     = fp_in[31:16] + {15'h0000, inc};
                res.inexact = lost;
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/bfn_lane_merge.sv
module bfn_lane_merge
    import bfn_pkg::*;
(
    input  logic              act,
    input  logic              zmode,
    input  logic [HALF_W-1:0] cvt_val,
    input  logic [LANE_W-1:0] old_lane,
    output logic [LANE_W-1:0] new_lane
);
    logic [HALF_W-1:0] upper;

    always_comb begin
        if (act)
            upper = cvt_val;
        else if (zmode)
            upper = '0;
        else
            upper = old_lane[LANE_W-1:HALF_W];
    end

    assign new_lane = {upper, old_lane[HALF_W-1:0]};
endmodule

// File: rtl/bfn_narrow_top.sv
module bfn_narrow_top
    import bfn_pkg::*;
#(
    parameter int VL = 256
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [VL-1:0]   src_vec,
    input  logic [VL-1:0]   old_dst,
    input  logic [VL/8-1:0] pred,
    input  logic            zero_mode,
    input  logic [1:0]      round_mode,
    input  logic            flush_den,
    output logic [VL-1:0]   dst_vec,
    output logic            inexact,
    output logic            invalid
);
    localparam int NLANE = VL / LANE_W;
    localparam int PSTEP = LANE_W / 8;

    logic [NLANE-1:0] act_v;
    logic [NLANE-1:0] ix_v;
    logic [NLANE-1:0] sn_v;
    logic [VL-1:0]    dst_d;
    logic             ix_d;
    logic             iv_d;
    logic             unused_pred;
    rmode_e           rm;

    assign rm          = rmode_e'(round_mode);
    assign unused_pred = ^pred;

    for (genvar e = 0; e < NLANE; e++) begin : g_lane
        cvt_res_t r;

        assign act_v[e] = pred[PSTEP*e];

        bfn_lane_cvt u_cvt (
            .fp_in (src_vec[LANE_W*e +: LANE_W]),
            .rm    (rm),
            .ftz   (flush_den),
            .res   (r)
        );

        bfn_lane_merge u_merge (
            .act      (act_v[e]),
            .zmode    (zero_mode),
            .cvt_val  (r.val),
            .old_lane (old_dst[LANE_W*e +: LANE_W]),
            .new_lane (dst_d[LANE_W*e +: LANE_W])
        );

        assign ix_v[e] = act_v[e] & r.inexact;
        assign sn_v[e] = act_v[e] & r.snan;
    end

    assign ix_d = |ix_v;
    assign iv_d = |sn_v;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dst_vec <= '0;
            inexact <= 1'b0;
            invalid <= 1'b0;
        end else begin
            dst_vec <= dst_d;
            inexact <= ix_d;
            invalid <= iv_d;
        end
    end
endmodule

// File: rtl/bfn_narrow_chk.sv
module bfn_narrow_chk #(
    parameter int VL = 256
) (
    input logic            clk,
    input logic            rst_n,
    input logic [VL-1:0]   old_dst,
    input logic [VL/8-1:0] pred,
    input logic            zero_mode,
    input logic [VL-1:0]   dst_vec,
    input logic            inexact,
    input logic            invalid
);
    localparam int NLANE = VL / 32;

    logic any_act;
    always_comb begin
        any_act = 1'b0;
        for (int e = 0; e < NLANE; e++) any_act |= pred[4*e];
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (dst_vec == '0 && !inexact && !invalid));

    a_r11_r12_idle_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(any_act)) |-> (!inexact && !invalid));

    for (genvar e = 0; e < NLANE; e++) begin : g_chk
        a_r3_low_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |-> dst_vec[32*e +: 16] == $past(old_dst[32*e +: 16]));

        a_r5_merge_inactive: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(pred[4*e]) && !$past(zero_mode))
            |-> dst_vec[32*e+16 +: 16] == $past(old_dst[32*e+16 +: 16]));

        a_r6_zero_inactive: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && !$past(pred[4*e]) && $past(zero_mode))
            |-> dst_vec[32*e+16 +: 16] == 16'h0000);
    end
endmodule

bind bfn_narrow_top bfn_narrow_chk #(.VL(VL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .old_dst   (old_dst),
    .pred      (pred),
    .zero_mode (zero_mode),
    .dst_vec   (dst_vec),
    .inexact   (inexact),
    .invalid   (invalid)
);

// File: tb/bfn_narrow_top_test.sv
module bfn_narrow_top_test;
    localparam int VL = 256;
    localparam int NL = VL / 32;

    typedef struct packed {
        logic [31:0] src;
        logic [1:0]  rm;
        logic        ftz;
        logic [15:0] res;
        logic        ix;
        logic        iv;
    } vec_t;

    localparam vec_t TBL [18] = '{
        '{32'h3F80_0000, 2'b00, 1'b0, 16'h3F80, 1'b0, 1'b0}, // R7 exact
        '{32'h3F80_8000, 2'b00, 1'b0, 16'h3F80, 1'b1, 1'b0}, // R7 tie to even, down
        '{32'h3F81_8000, 2'b00, 1'b0, 16'h3F82, 1'b1, 1'b0}, // R7 tie to even, up
        '{32'h3F80_8001, 2'b00, 1'b0, 16'h3F81, 1'b1, 1'b0}, // R7 above half
        '{32'h3F80_7FFF, 2'b00, 1'b0, 16'h3F80, 1'b1, 1'b0}, // R7 below half
        '{32'h7F7F_FFFF, 2'b00, 1'b0, 16'h7F80, 1'b1, 1'b0}, // R7 overflow to inf
        '{32'h7F7F_FFFF, 2'b11, 1'b0, 16'h7F7F, 1'b1, 1'b0}, // R8 truncate
        '{32'h3F80_0001, 2'b01, 1'b0, 16'h3F81, 1'b1, 1'b0}, // R8 up, positive
        '{32'hBF80_0001, 2'b01, 1'b0, 16'hBF80, 1'b1, 1'b0}, // R8 up, negative
        '{32'hBF80_0001, 2'b10, 1'b0, 16'hBF81, 1'b1, 1'b0}, // R8 down, negative
        '{32'h7FA0_0000, 2'b00, 1'b0, 16'h7FE0, 1'b0, 1'b1}, // R9 R12 signaling NaN
        '{32'hFFC0_0001, 2'b00, 1'b0, 16'hFFC0, 1'b0, 1'b0}, // R9 quiet NaN
        '{32'hFF80_0000, 2'b00, 1'b0, 16'hFF80, 1'b0, 1'b0}, // R9 -inf
        '{32'h8000_0000, 2'b00, 1'b0, 16'h8000, 1'b0, 1'b0}, // R9 -zero
        '{32'h0000_8001, 2'b00, 1'b1, 16'h0000, 1'b0, 1'b0}, // R10 flushed
        '{32'h0000_8001, 2'b00, 1'b0, 16'h0001, 1'b1, 1'b0}, // R10 rounded denormal
        '{32'h8000_0001, 2'b10, 1'b0, 16'h8001, 1'b1, 1'b0}, // R10 R8 denormal down
        '{32'h7F80_0000, 2'b01, 1'b0, 16'h7F80, 1'b0, 1'b0}  // R9 R11 inf exact
    };

    logic            clk = 1'b0;
    logic            rst_n;
    logic [VL-1:0]   src_vec;
    logic [VL-1:0]   old_dst;
    logic [VL/8-1:0] pred;
    logic            zero_mode;
    logic [1:0]      round_mode;
    logic            flush_den;
    logic [VL-1:0]   dst_vec;
    logic            inexact;
    logic            invalid;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    bfn_narrow_top #(.VL(VL)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_vec    (src_vec),
        .old_dst    (old_dst),
        .pred       (pred),
        .zero_mode  (zero_mode),
        .round_mode (round_mode),
        .flush_den  (flush_den),
        .dst_vec    (dst_vec),
        .inexact    (inexact),
        .invalid    (invalid)
    );

    function automatic logic [VL-1:0] old_pat();
        logic [VL-1:0] v;
        for (int e = 0; e < NL; e++)
            v[32*e +: 32] = {16'hC000 + 16'(e), 16'h5A00 + 16'(e)};
        return v;
    endfunction

    // expected vector: active lanes take val[e], inactive keep or clear
    function automatic logic [VL-1:0] expect_vec(logic [NL-1:0] act, logic zm,
                                                 logic [NL*16-1:0] vals);
        logic [VL-1:0] o = old_pat();
        logic [VL-1:0] v;
        for (int e = 0; e < NL; e++) begin
            v[32*e +: 16] = o[32*e +: 16];
            if (act[e])      v[32*e+16 +: 16] = vals[16*e +: 16];
            else if (zm)     v[32*e+16 +: 16] = 16'h0000;
            else             v[32*e+16 +: 16] = o[32*e+16 +: 16];
        end
        return v;
    endfunction

    task automatic check(string req, logic [VL-1:0] exp_d, logic exp_ix, logic exp_iv);
        n_chk++;
        if (dst_vec !== exp_d || inexact !== exp_ix || invalid !== exp_iv) begin
            n_bad++;
            $display("FAIL %s: got dst=%h ix=%b iv=%b, expected dst=%h ix=%b iv=%b",
                     req, dst_vec, inexact, invalid, exp_d, exp_ix, exp_iv);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [NL*16-1:0] vals;
        logic [VL/8-1:0]  p;

        rst_n      = 1'b0;
        src_vec    = {NL{32'h3F80_8001}};
        old_dst    = old_pat();
        pred       = '1;
        zero_mode  = 1'b0;
        round_mode = 2'b00;
        flush_den  = 1'b0;
        @(negedge clk);
        step();
        check("R1 reset", '0, 1'b0, 1'b0);
        rst_n = 1'b1;

        // R2 R11: table walk, same value in all lanes, all active, merge mode
        for (int i = 0; i < 18; i++) begin
            src_vec    = {NL{TBL[i].src}};
            round_mode = TBL[i].rm;
            flush_den  = TBL[i].ftz;
            pred       = '1;
            step();
            check($sformatf("R2 R7-R12 vector %0d", i),
                  expect_vec('1, 1'b0, {NL{TBL[i].res}}), TBL[i].ix, TBL[i].iv);
        end

        // R2: distinct value per lane lands in its own upper half
        round_mode = 2'b00;
        flush_den  = 1'b0;
        for (int e = 0; e < NL; e++) begin
            src_vec[32*e +: 32] = {16'h3F80 + 16'(e), 16'h0000};
            vals[16*e +: 16]    = 16'h3F80 + 16'(e);
        end
        step();
        check("R2 lane placement", expect_vec('1, 1'b0, vals), 1'b0, 1'b0);

        // R4 R5: lanes 0,2,5 active; inactive lanes set the ignored bits
        p = '0;
        for (int e = 0; e < NL; e++) begin
            if (e == 0 || e == 2 || e == 5) p[4*e] = 1'b1;
            else p[4*e +: 4] = 4'b1110;
        end
        pred = p;
        zero_mode = 1'b0;
        step();
        check("R4 R5 merge inactive", expect_vec(NL'(8'b0010_0101), 1'b0, vals), 1'b0, 1'b0);

        // R3 R6: same in zero mode
        zero_mode = 1'b1;
        step();
        check("R3 R6 zero inactive", expect_vec(NL'(8'b0010_0101), 1'b1, vals), 1'b0, 1'b0);

        // R6: all inactive in zero mode clears every upper half
        pred = '0;
        step();
        check("R6 all inactive", expect_vec('0, 1'b1, vals), 1'b0, 1'b0);

        // R11 R12: sNaN and inexact value only on inactive lane 1
        zero_mode = 1'b0;
        pred = p;
        src_vec[63:32] = 32'h7FA0_0000;
        src_vec[95:64] = 32'h3F80_0000;
        vals[47:32]    = 16'h3F80;
        step();
        check("R11 R12 inactive lane flags ignored",
              expect_vec(NL'(8'b0010_0101), 1'b0, vals), 1'b0, 1'b0);

        src_vec[63:32] = 32'h3F80_0001;
        step();
        check("R11 inactive inexact ignored",
              expect_vec(NL'(8'b0010_0101), 1'b0, vals), 1'b0, 1'b0);

        // R12: activate lane 1 holding sNaN
        src_vec[63:32] = 32'h7FA0_0000;
        pred[4] = 1'b1;
        vals[31:16] = 16'h7FE0;
        step();
        check("R12 active sNaN", expect_vec(NL'(8'b0010_0111), 1'b0, vals), 1'b0, 1'b1);

        // R11: active inexact lane
        src_vec[63:32] = 32'h3F80_0001;
        vals[31:16] = 16'h3F80;
        step();
        check("R11 active inexact", expect_vec(NL'(8'b0010_0111), 1'b0, vals), 1'b1, 1'b0);

        // R1: reset again mid-run clears outputs
        rst_n = 1'b0;
        step();
        check("R1 reset mid-run", '0, 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule